// File: doc/BRIEF.md
# Double-Edge Request Packet Decoder

This block sits behind the request pins of a high-speed memory device. A 12-bit, active-low request bus carries one command every clock cycle: a first half sampled on the falling clock edge and a second half sampled on the rising edge that follows. The block inverts the lines, joins the halves into one 24-bit packet, finds the packet type from a variable-length opcode prefix, and pulls out the bank, row, column, sub-column, sub-row, mask and refresh fields.

Column, row-activate, precharge and refresh commands may ask for their effect to be postponed by a few cycles. Each of these four classes has its own short delay line, so commands of different classes can all take effect in the same cycle. Each operation class drives a one-cycle strobe together with its fields. A separate error strobe marks packets that are malformed or that cannot be scheduled.

Top module: `rqd_top`

## Requirements
- R1: The first half (packet bits 23..12, called H bits 11..0 below) is taken from `rq_n` on the falling edge. The second half (L bits 11..0) is taken on the next rising edge. A low line is a logic 1. When every line is high the packet is a no-op and no strobe follows.
- R2: The type is set by H[11:8]: 0000 no-op, 0001 column, 0010 miscellaneous, 0011 precharge/refresh, 01xx row activate, 1xxx masked write. A no-op with arbitrary H[7:0] and L bits raises no strobe.
- R3: Column command fields: write flag = H[7]; column address {C11..C4} = {H[3],H[4],H[5],H[6],L[7:4]}; bank = H[2:0]; sub-column = L[3:0]; delay = L[11]. With delay 0, `col_vld_o` is high for the one cycle after the rising edge that completes the packet.
- R4: Row activate fields: row {R15..R0} = {H[3],H[4],H[5],H[6],H[7],H[8],H[9],L[10:2]}; bank = H[2:0]; sub-row = L[1:0]; delay = L[11].
- R5: Masked write fields: mask {M7..M0} = {L[11:8],H[10:7]}; column and sub-column as in R3; bank = H[2:0]. It takes no delay, so `mwr_vld_o` rises in the cycle after the packet.
- R6: Precharge is enabled by L[11]. Its bank is H[2:0] and its delay (0 to 3) is H[7:6].
- R7: Refresh is enabled when the refresh code L[10:8] is non-zero. It reports that code, the bank L[2:0] and the delay (0 to 3) L[7:6].
- R8: If precharge and refresh are both enabled and name the same bank, `err_o` pulses in the cycle after the packet. Neither operation is issued.
- R9: Miscellaneous code H[3:0] = 1, 2, 3, 4 gives `misc_op_o` = 0 (calibration start), 1 (calibration sample), 2 (calibration stop), 3 (power-down) with `misc_vld_o`. Any other code pulses `err_o` and raises no `misc_vld_o`.
- R10: A command with delay d shows its strobe d cycles later than it would with delay 0.
- R11: Commands of different classes that mature in the same cycle all appear in that cycle.
- R12: If a new command would mature in the same cycle as an already queued command of the same class, the queued one still appears, the new one is dropped, and `err_o` pulses in the cycle after the new packet.
- R13: While `rst_n` is low, every strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Request clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rq_n | input | 12 | Request bus, active low |
| col_vld_o | output | 1 | Column read/write strobe |
| col_wr_o | output | 1 | Column command is a write |
| col_bank_o | output | 3 | Column bank |
| col_addr_o | output | 8 | Column address C11..C4 |
| col_sub_o | output | 4 | Sub-column SC3..SC0 |
| act_vld_o | output | 1 | Row activate strobe |
| act_bank_o | output | 3 | Activate bank |
| act_row_o | output | 16 | Row address R15..R0 |
| act_subrow_o | output | 2 | Sub-row SR1..SR0 |
| mwr_vld_o | output | 1 | Masked write strobe |
| mwr_bank_o | output | 3 | Masked write bank |
| mwr_addr_o | output | 8 | Masked write column C11..C4 |
| mwr_sub_o | output | 4 | Masked write sub-column |
| mwr_mask_o | output | 8 | Fill pattern M7..M0 |
| pre_vld_o | output | 1 | Precharge strobe |
| pre_bank_o | output | 3 | Precharge bank |
| ref_vld_o | output | 1 | Refresh strobe |
| ref_bank_o | output | 3 | Refresh bank |
| ref_op_o | output | 3 | Refresh code |
| misc_vld_o | output | 1 | Miscellaneous command strobe |
| misc_op_o | output | 2 | Miscellaneous operation index |
| err_o | output | 1 | Malformed or colliding packet |

## Verification
The assertions assume that the second half of each packet on `rq_n` is stable at the rising edge and that the first half held since the falling edge belongs to the same packet. They therefore assume the bus changes only between edges. They also assume the only same-class collisions are the ones R12 defines. The stimulus changes `rq_n` one nanosecond after each edge and never leaves a half undriven. Outside the dedicated R12 sequence, it spaces the delayed commands so that no two of one class mature together.

// File: rtl/rqd_pkg.sv
// Shared widths, field records and code points for the request decoder.
package rqd_pkg;
    localparam int RQ_W      = 12;
    localparam int BANK_W    = 3;
    localparam int COL_W     = 8;
    localparam int SUB_W     = 4;
    localparam int ROW_W     = 16;
    localparam int SROW_W    = 2;
    localparam int MASK_W    = 8;
    localparam int ROP_W     = 3;
    localparam int MOP_W     = 2;
    localparam int DLY_DEPTH = 4;
    localparam int DLY_W     = $clog2(DLY_DEPTH);
    localparam int PKT_W     = 2 * RQ_W;

    // Miscellaneous subcommand code points (first-half bits 3..0)
    localparam logic [3:0] XOP_CAL_START  = 4'h1;
    localparam logic [3:0] XOP_CAL_SAMPLE = 4'h2;
    localparam logic [3:0] XOP_CAL_STOP   = 4'h3;
    localparam logic [3:0] XOP_POWER_DOWN = 4'h4;

    typedef enum logic [2:0] {
        K_NOP, K_COL, K_MISC, K_PRF, K_ACT, K_MWR
    } pkt_kind_e;

    typedef struct packed {
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  addr;
        logic [SUB_W-1:0]  sub;
    } col_cmd_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [SROW_W-1:0] subrow;
    } act_cmd_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  addr;
        logic [SUB_W-1:0]  sub;
        logic [MASK_W-1:0] mask;
    } mwr_cmd_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROP_W-1:0]  op;
    } ref_cmd_t;
endpackage

// File: rtl/rqd_capture.sv
// Double-edge capture of the request bus.
// The first half is latched on the falling edge and the second half is used
// straight from the pins on the rising edge. Both are inverted so that the
// outputs are logic-1 true. Assumes the bus is stable around each edge.
module rqd_capture
    import rqd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RQ_W-1:0]  rq_n,
    output logic [RQ_W-1:0]  first_half,
    output logic [PKT_W-1:0] packet
);
    logic [RQ_W-1:0] first_q;

    // Hold the inverted falling-edge half until the next rising edge
    always_ff @(negedge clk) begin
        if (!rst_n) first_q <= '0;
        else        first_q <= ~rq_n;
    end

    assign first_half = first_q;
    assign packet     = {first_q, ~rq_n};
endmodule

// File: rtl/rqd_classify.sv
// Combinational packet classifier and field extractor.
// Takes one assembled packet (logic-1 true) and produces per-class valid
// flags, delays and field records. It drops malformed packets and flags them
// on bad_cmd. Holds no state.
module rqd_classify
    import rqd_pkg::*;
(
    input  logic [PKT_W-1:0] packet,
    output logic             col_vld,
    output logic [DLY_W-1:0] col_dly,
    output col_cmd_t         col,
    output logic             act_vld,
    output logic [DLY_W-1:0] act_dly,
    output act_cmd_t         act,
    output logic             mwr_vld,
    output mwr_cmd_t         mwr,
    output logic             pre_vld,
    output logic [DLY_W-1:0] pre_dly,
    output logic [BANK_W-1:0] pre_bank,
    output logic             ref_vld,
    output logic [DLY_W-1:0] ref_dly,
    output ref_cmd_t         refr,
    output logic             misc_vld,
    output logic [MOP_W-1:0] misc_op,
    output logic             bad_cmd
);
    logic [RQ_W-1:0] hi, lo;
    pkt_kind_e       kind;
    logic            pre_en, ref_en, same_bank, misc_ok;

    assign hi = packet[PKT_W-1:RQ_W];
    assign lo = packet[RQ_W-1:0];

    // Decode the variable-length opcode prefix
    always_comb begin
        if (hi[11])      kind = K_MWR;
        else if (hi[10]) kind = K_ACT;
        else begin
            case (hi[9:8])
                2'b00:   kind = K_NOP;
                2'b01:   kind = K_COL;
                2'b10:   kind = K_MISC;
                default: kind = K_PRF;
            endcase
        end
    end

    // Column fields: high column bits arrive in reverse order
    assign col_vld   = (kind == K_COL);
    assign col_dly   = DLY_W'(lo[11]);
    assign col.wr    = hi[7];
    assign col.bank  = hi[2:0];
    assign col.addr  = {hi[3], hi[4], hi[5], hi[6], lo[7:4]};
    assign col.sub   = lo[3:0];

    // Row activate fields: upper row bits spread over the first half
    assign act_vld    = (kind == K_ACT);
    assign act_dly    = DLY_W'(lo[11]);
    assign act.bank   = hi[2:0];
    assign act.row    = {hi[3], hi[4], hi[5], hi[6], hi[7], hi[8], hi[9], lo[10:2]};
    assign act.subrow = lo[1:0];

    // Masked write fields: mask split across both halves, never delayed
    assign mwr_vld  = (kind == K_MWR);
    assign mwr.bank = hi[2:0];
    assign mwr.addr = {hi[3], hi[4], hi[5], hi[6], lo[7:4]};
    assign mwr.sub  = lo[3:0];
    assign mwr.mask = {lo[11:8], hi[10:7]};

    // Precharge/refresh pair with same-bank rejection
    assign pre_en    = lo[11];
    assign ref_en    = |lo[10:8];
    assign same_bank = pre_en && ref_en && (hi[2:0] == lo[2:0]);
    assign pre_vld   = (kind == K_PRF) && pre_en && !same_bank;
    assign ref_vld   = (kind == K_PRF) && ref_en && !same_bank;
    assign pre_dly   = hi[7:6];
    assign pre_bank  = hi[2:0];
    assign ref_dly   = lo[7:6];
    assign refr.bank = lo[2:0];
    assign refr.op   = lo[10:8];

    // Map the four legal miscellaneous codes to an operation index
    always_comb begin
        misc_ok = 1'b1;
        case (hi[3:0])
            XOP_CAL_START:  misc_op = 2'd0;
            XOP_CAL_SAMPLE: misc_op = 2'd1;
            XOP_CAL_STOP:   misc_op = 2'd2;
            XOP_POWER_DOWN: misc_op = 2'd3;
            default: begin
                misc_op = 2'd0;
                misc_ok = 1'b0;
            end
        endcase
    end

    assign misc_vld = (kind == K_MISC) && misc_ok;
    assign bad_cmd  = ((kind == K_MISC) && !misc_ok) || ((kind == K_PRF) && same_bank);
endmodule

// File: rtl/rqd_delay_line.sv
// Per-class delay line with DEPTH slots. Slot 0 is the output.
// A command with delay d is written to slot d. Every other slot moves one
// place toward the output each cycle. If the target slot will already be
// filled by an older command, the new one is dropped and collide is raised
// for that cycle. Assumes in_dly < DEPTH.
module rqd_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [$clog2(DEPTH)-1:0] in_dly,
    input  logic [W-1:0]             in_data,
    output logic                     out_vld,
    output logic [W-1:0]             out_data,
    output logic                     collide
);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     dat_q [DEPTH];
    logic [DEPTH-1:0] coll_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic         up_v;
        logic [W-1:0] up_d;
        logic         hit;
        logic         v_q;
        logic [W-1:0] d_q;

        if (i == DEPTH - 1) begin : g_last
            assign up_v = 1'b0;
            assign up_d = '0;
        end else begin : g_inner
            assign up_v = vld_q[i+1];
            assign up_d = dat_q[i+1];
        end

        assign hit         = in_vld && (in_dly == IW'(i));
        assign coll_vec[i] = hit && up_v;

        // Load a new command into a free slot, otherwise shift toward output
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (hit && !up_v) begin
                v_q <= 1'b1;
                d_q <= in_data;
            end else begin
                v_q <= up_v;
                d_q <= up_d;
            end
        end

        assign vld_q[i] = v_q;
        assign dat_q[i] = d_q;
    end

    assign out_vld  = vld_q[0];
    assign out_data = dat_q[0];
    assign collide  = |coll_vec;
endmodule

// File: rtl/rqd_top.sv
// Request packet decoder top.
// Captures the double-edge request bus, classifies each packet, routes the
// delayable classes through their own delay lines and registers the
// undelayable ones. Every strobe lasts one cycle. err_o gathers malformed
// packets and same-class collisions. Reset is synchronous and active low.
module rqd_top
    import rqd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RQ_W-1:0]   rq_n,
    output logic              col_vld_o,
    output logic              col_wr_o,
    output logic [BANK_W-1:0] col_bank_o,
    output logic [COL_W-1:0]  col_addr_o,
    output logic [SUB_W-1:0]  col_sub_o,
    output logic              act_vld_o,
    output logic [BANK_W-1:0] act_bank_o,
    output logic [ROW_W-1:0]  act_row_o,
    output logic [SROW_W-1:0] act_subrow_o,
    output logic              mwr_vld_o,
    output logic [BANK_W-1:0] mwr_bank_o,
    output logic [COL_W-1:0]  mwr_addr_o,
    output logic [SUB_W-1:0]  mwr_sub_o,
    output logic [MASK_W-1:0] mwr_mask_o,
    output logic              pre_vld_o,
    output logic [BANK_W-1:0] pre_bank_o,
    output logic              ref_vld_o,
    output logic [BANK_W-1:0] ref_bank_o,
    output logic [ROP_W-1:0]  ref_op_o,
    output logic              misc_vld_o,
    output logic [MOP_W-1:0]  misc_op_o,
    output logic              err_o
);
    logic [RQ_W-1:0]   first_half;
    logic [PKT_W-1:0]  packet;

    logic              d_col_vld, d_act_vld, d_mwr_vld, d_pre_vld, d_ref_vld, d_misc_vld;
    logic [DLY_W-1:0]  d_col_dly, d_act_dly, d_pre_dly, d_ref_dly;
    col_cmd_t          d_col, q_col;
    act_cmd_t          d_act, q_act;
    mwr_cmd_t          d_mwr, mwr_q;
    ref_cmd_t          d_ref, q_ref;
    logic [BANK_W-1:0] d_pre_bank, q_pre_bank;
    logic [MOP_W-1:0]  d_misc_op, misc_op_q;
    logic              bad_cmd;
    logic              coll_col, coll_act, coll_pre, coll_ref;
    logic              mwr_v_q, misc_v_q, err_q;

    rqd_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .rq_n       (rq_n),
        .first_half (first_half),
        .packet     (packet)
    );

    rqd_classify u_cls (
        .packet   (packet),
        .col_vld  (d_col_vld),
        .col_dly  (d_col_dly),
        .col      (d_col),
        .act_vld  (d_act_vld),
        .act_dly  (d_act_dly),
        .act      (d_act),
        .mwr_vld  (d_mwr_vld),
        .mwr      (d_mwr),
        .pre_vld  (d_pre_vld),
        .pre_dly  (d_pre_dly),
        .pre_bank (d_pre_bank),
        .ref_vld  (d_ref_vld),
        .ref_dly  (d_ref_dly),
        .refr     (d_ref),
        .misc_vld (d_misc_vld),
        .misc_op  (d_misc_op),
        .bad_cmd  (bad_cmd)
    );

    rqd_delay_line #(.W($bits(col_cmd_t)), .DEPTH(DLY_DEPTH)) u_dl_col (
        .clk (clk), .rst_n (rst_n),
        .in_vld (d_col_vld), .in_dly (d_col_dly), .in_data (d_col),
        .out_vld (col_vld_o), .out_data (q_col), .collide (coll_col)
    );

    rqd_delay_line #(.W($bits(act_cmd_t)), .DEPTH(DLY_DEPTH)) u_dl_act (
        .clk (clk), .rst_n (rst_n),
        .in_vld (d_act_vld), .in_dly (d_act_dly), .in_data (d_act),
        .out_vld (act_vld_o), .out_data (q_act), .collide (coll_act)
    );

    rqd_delay_line #(.W(BANK_W), .DEPTH(DLY_DEPTH)) u_dl_pre (
        .clk (clk), .rst_n (rst_n),
        .in_vld (d_pre_vld), .in_dly (d_pre_dly), .in_data (d_pre_bank),
        .out_vld (pre_vld_o), .out_data (q_pre_bank), .collide (coll_pre)
    );

    rqd_delay_line #(.W($bits(ref_cmd_t)), .DEPTH(DLY_DEPTH)) u_dl_ref (
        .clk (clk), .rst_n (rst_n),
        .in_vld (d_ref_vld), .in_dly (d_ref_dly), .in_data (d_ref),
        .out_vld (ref_vld_o), .out_data (q_ref), .collide (coll_ref)
    );

    // Register the undelayable classes and the combined error strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mwr_v_q   <= 1'b0;
            mwr_q     <= '0;
            misc_v_q  <= 1'b0;
            misc_op_q <= '0;
            err_q     <= 1'b0;
        end else begin
            mwr_v_q   <= d_mwr_vld;
            mwr_q     <= d_mwr;
            misc_v_q  <= d_misc_vld;
            misc_op_q <= d_misc_op;
            err_q     <= bad_cmd | coll_col | coll_act | coll_pre | coll_ref;
        end
    end

    assign col_wr_o     = q_col.wr;
    assign col_bank_o   = q_col.bank;
    assign col_addr_o   = q_col.addr;
    assign col_sub_o    = q_col.sub;
    assign act_bank_o   = q_act.bank;
    assign act_row_o    = q_act.row;
    assign act_subrow_o = q_act.subrow;
    assign mwr_vld_o    = mwr_v_q;
    assign mwr_bank_o   = mwr_q.bank;
    assign mwr_addr_o   = mwr_q.addr;
    assign mwr_sub_o    = mwr_q.sub;
    assign mwr_mask_o   = mwr_q.mask;
    assign pre_bank_o   = q_pre_bank;
    assign ref_bank_o   = q_ref.bank;
    assign ref_op_o     = q_ref.op;
    assign misc_vld_o   = misc_v_q;
    assign misc_op_o    = misc_op_q;
    assign err_o        = err_q;
endmodule

// File: rtl/rqd_checker.sv
// Temporal checks for rqd_top. They relate the captured first half and the
// live bus at a rising edge to the strobes that must follow.
module rqd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] rq_n,
    input logic [11:0] first_half,
    input logic        col_vld_o,
    input logic        act_vld_o,
    input logic        mwr_vld_o,
    input logic [7:0]  mwr_mask_o,
    input logic        misc_vld_o,
    input logic        err_o
);
    // Undelayed column command strobes next cycle (R3)
    assert_col_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_half[11:8] == 4'b0001 && rq_n[11]) |=> col_vld_o);

    // Masked write issues at once with its low mask nibble (R5)
    assert_mwr_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        first_half[11] |=> (mwr_vld_o && mwr_mask_o[3:0] == $past(first_half[10:7])));

    // Activate with delay one strobes two edges later (R10)
    assert_act_late_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (first_half[11:10] == 2'b01 && !rq_n[11]) |-> ##2 act_vld_o);

    // Illegal miscellaneous code errors and stays silent (R9)
    assert_misc_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (first_half[11:8] == 4'b0010 && (first_half[3:0] == 4'h0 || first_half[3:0] > 4'h4))
        |=> (err_o && !misc_vld_o));

    // Precharge and refresh on one bank is flagged (R8)
    assert_same_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (first_half[11:8] == 4'b0011 && !rq_n[11] && rq_n[10:8] != 3'b111
         && first_half[2:0] == ~rq_n[2:0]) |=> err_o);
endmodule

bind rqd_top rqd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rq_n       (rq_n),
    .first_half (first_half),
    .col_vld_o  (col_vld_o),
    .act_vld_o  (act_vld_o),
    .mwr_vld_o  (mwr_vld_o),
    .mwr_mask_o (mwr_mask_o),
    .misc_vld_o (misc_vld_o),
    .err_o      (err_o)
);

// File: tb/rqd_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected strobes, each tagged with
// the cycle it is due in. A monitor compares every class in every cycle.
module rqd_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] rq_n = '1;

    logic        col_vld_o, col_wr_o;
    logic [2:0]  col_bank_o;
    logic [7:0]  col_addr_o;
    logic [3:0]  col_sub_o;
    logic        act_vld_o;
    logic [2:0]  act_bank_o;
    logic [15:0] act_row_o;
    logic [1:0]  act_subrow_o;
    logic        mwr_vld_o;
    logic [2:0]  mwr_bank_o;
    logic [7:0]  mwr_addr_o;
    logic [3:0]  mwr_sub_o;
    logic [7:0]  mwr_mask_o;
    logic        pre_vld_o;
    logic [2:0]  pre_bank_o;
    logic        ref_vld_o;
    logic [2:0]  ref_bank_o;
    logic [2:0]  ref_op_o;
    logic        misc_vld_o;
    logic [1:0]  misc_op_o;
    logic        err_o;

    rqd_top u_dut (
        .clk (clk), .rst_n (rst_n), .rq_n (rq_n),
        .col_vld_o (col_vld_o), .col_wr_o (col_wr_o), .col_bank_o (col_bank_o),
        .col_addr_o (col_addr_o), .col_sub_o (col_sub_o),
        .act_vld_o (act_vld_o), .act_bank_o (act_bank_o), .act_row_o (act_row_o),
        .act_subrow_o (act_subrow_o),
        .mwr_vld_o (mwr_vld_o), .mwr_bank_o (mwr_bank_o), .mwr_addr_o (mwr_addr_o),
        .mwr_sub_o (mwr_sub_o), .mwr_mask_o (mwr_mask_o),
        .pre_vld_o (pre_vld_o), .pre_bank_o (pre_bank_o),
        .ref_vld_o (ref_vld_o), .ref_bank_o (ref_bank_o), .ref_op_o (ref_op_o),
        .misc_vld_o (misc_vld_o), .misc_op_o (misc_op_o), .err_o (err_o)
    );

    always #2.5 clk = ~clk;

    localparam int C_COL = 0, C_ACT = 1, C_MWR = 2, C_PRE = 3, C_REF = 4,
                   C_MISC = 5, C_ERR = 6, NCLS = 7;

    typedef struct {
        int          due;
        int          cls;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    string quiet_tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic vld_of(int c);
        case (c)
            C_COL:   return col_vld_o;
            C_ACT:   return act_vld_o;
            C_MWR:   return mwr_vld_o;
            C_PRE:   return pre_vld_o;
            C_REF:   return ref_vld_o;
            C_MISC:  return misc_vld_o;
            default: return err_o;
        endcase
    endfunction

    function automatic logic [31:0] word_of(int c);
        case (c)
            C_COL:   return 32'({col_wr_o, col_bank_o, col_addr_o, col_sub_o});
            C_ACT:   return 32'({act_bank_o, act_row_o, act_subrow_o});
            C_MWR:   return 32'({mwr_bank_o, mwr_addr_o, mwr_sub_o, mwr_mask_o});
            C_PRE:   return 32'(pre_bank_o);
            C_REF:   return 32'({ref_bank_o, ref_op_o});
            C_MISC:  return 32'(misc_op_o);
            default: return 32'd0;
        endcase
    endfunction

    // Monitor: pop the items due this cycle and compare every class
    task automatic monitor_cycle();
        for (int c = 0; c < NCLS; c++) begin
            bit          found = 1'b0;
            logic [31:0] ev = '0;
            string       tg = quiet_tag;
            for (int k = 0; k < sb.size(); k++) begin
                if (sb[k].due == cyc && sb[k].cls == c) begin
                    found = 1'b1;
                    ev = sb[k].val;
                    tg = sb[k].tag;
                    sb.delete(k);
                    break;
                end
            end
            check(tg, 32'(vld_of(c)), 32'(found));
            if (found && vld_of(c)) check(tg, word_of(c), ev);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (mon_en) monitor_cycle();
    end

    // Driver: one packet per cycle, first half before the falling edge
    task automatic send(logic [11:0] f, logic [11:0] s);
        @(posedge clk);
        #1 rq_n = ~f;
        @(negedge clk);
        #1 rq_n = ~s;
    endtask

    task automatic expect_item(int d, int cls, logic [31:0] val, string tag);
        sb.push_back('{due: cyc + 1 + d, cls: cls, val: val, tag: tag});
    endtask

    task automatic idle(int n);
        repeat (n) send(12'h000, 12'h000);
    endtask

    task automatic col_cmd(logic wr, logic [2:0] b, logic [7:0] a, logic [3:0] sc,
                           logic d, string tag);
        send({4'b0001, wr, a[4], a[5], a[6], a[7], b}, {d, 3'b000, a[3:0], sc});
        expect_item(int'(d), C_COL, 32'({wr, b, a, sc}), tag);
    endtask

    task automatic act_cmd(logic [2:0] b, logic [15:0] r, logic [1:0] sr,
                           logic d, string tag);
        send({2'b01, r[9], r[10], r[11], r[12], r[13], r[14], r[15], b}, {d, r[8:0], sr});
        expect_item(int'(d), C_ACT, 32'({b, r, sr}), tag);
    endtask

    task automatic mwr_cmd(logic [2:0] b, logic [7:0] a, logic [3:0] sc,
                           logic [7:0] m, string tag);
        send({1'b1, m[3:0], a[4], a[5], a[6], a[7], b}, {m[7:4], a[3:0], sc});
        expect_item(0, C_MWR, 32'({b, a, sc, m}), tag);
    endtask

    task automatic prf_send(logic pen, logic [1:0] pd, logic [2:0] pb,
                            logic [2:0] rop, logic [1:0] rd, logic [2:0] rb);
        send({4'b0011, pd, 3'b000, pb}, {pen, rop, rd, 3'b000, rb});
    endtask

    task automatic misc_send(logic [3:0] xop);
        send({4'b0010, 4'b0000, xop}, 12'h000);
    endtask

    initial begin
        // R13: strobes stay low during reset
        repeat (3) @(posedge clk);
        #3;
        for (int c = 0; c < NCLS; c++) check("R13", 32'(vld_of(c)), 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        mon_en = 1'b1;

        // R1: idle bus gives nothing
        idle(3);

        // R2: no-op with junk fields stays quiet
        quiet_tag = "R2";
        send(12'h0FF, 12'hFFF);
        send(12'h0A5, 12'h5A5);
        idle(2);
        quiet_tag = "R1";

        // R3 / R10: column commands
        col_cmd(1'b0, 3'd5, 8'hA7, 4'h9, 1'b0, "R3");
        col_cmd(1'b1, 3'd2, 8'h3C, 4'h6, 1'b1, "R10");
        idle(3);
        col_cmd(1'b1, 3'd7, 8'h81, 4'hF, 1'b0, "R3");
        idle(3);

        // R4 / R10: row activate
        act_cmd(3'd7, 16'hB5E1, 2'b10, 1'b0, "R4");
        act_cmd(3'd1, 16'h4A1E, 2'b01, 1'b1, "R10");
        idle(3);

        // R5: masked write
        mwr_cmd(3'd4, 8'h5A, 4'hC, 8'h96, "R5");
        mwr_cmd(3'd0, 8'hFF, 4'h0, 8'h01, "R5");
        idle(3);

        // R6: precharge only, delay 2
        prf_send(1'b1, 2'd2, 3'd6, 3'd0, 2'd0, 3'd0);
        expect_item(2, C_PRE, 32'd6, "R6");
        idle(4);
        // R7: refresh only, delay 3
        prf_send(1'b0, 2'd0, 3'd0, 3'd5, 2'd3, 3'd1);
        expect_item(3, C_REF, 32'({3'd1, 3'd5}), "R7");
        idle(5);
        // R6 / R7: both, different banks
        prf_send(1'b1, 2'd0, 3'd2, 3'd3, 2'd1, 3'd4);
        expect_item(0, C_PRE, 32'd2, "R6");
        expect_item(1, C_REF, 32'({3'd4, 3'd3}), "R7");
        idle(4);

        // R8: same bank rejected
        prf_send(1'b1, 2'd1, 3'd3, 3'd2, 2'd0, 3'd3);
        expect_item(0, C_ERR, 32'd0, "R8");
        idle(4);

        // R9: legal and illegal miscellaneous codes
        for (int x = 1; x <= 4; x++) begin
            misc_send(4'(x));
            expect_item(0, C_MISC, 32'(x - 1), "R9");
        end
        misc_send(4'h9);
        expect_item(0, C_ERR, 32'd0, "R9");
        misc_send(4'h0);
        expect_item(0, C_ERR, 32'd0, "R9");
        idle(3);

        // R11: four classes maturing in one cycle
        prf_send(1'b1, 2'd3, 3'd1, 3'd0, 2'd0, 3'd0);
        expect_item(3, C_PRE, 32'd1, "R11");
        prf_send(1'b0, 2'd0, 3'd0, 3'd7, 2'd2, 3'd0);
        expect_item(2, C_REF, 32'({3'd0, 3'd7}), "R11");
        act_cmd(3'd5, 16'h0F0F, 2'b11, 1'b1, "R11");
        col_cmd(1'b0, 3'd2, 8'h44, 4'h2, 1'b0, "R11");
        idle(4);

        // R12: same-class collisions
        col_cmd(1'b1, 3'd1, 8'h12, 4'h3, 1'b1, "R12");
        send({4'b0001, 1'b0, 4'b0000, 3'd4}, 12'h000);
        expect_item(0, C_ERR, 32'd0, "R12");
        idle(3);
        prf_send(1'b1, 2'd3, 3'd5, 3'd0, 2'd0, 3'd0);
        expect_item(3, C_PRE, 32'd5, "R12");
        prf_send(1'b1, 2'd2, 3'd6, 3'd0, 2'd0, 3'd0);
        expect_item(0, C_ERR, 32'd0, "R12");
        idle(6);

        // R10: every queued item has matured
        check("R10", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: counts as a failed check
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule